// File: doc/BRIEF.md
# SD/MMC Multi-Block Data Line Engine

This block is the host-side data path of an SD/MMC controller. It moves whole blocks of data over the card's DAT lines, either on DAT0 alone (1-bit mode) or on DAT3..DAT0 together (4-bit mode). Each block is framed with a start bit, the payload, one CRC16 per active lane and an end bit. On reads it checks the CRC of every block. On writes it generates the CRC, then collects the card's CRC status token and waits out the card's busy period before sending the next block. Commands are issued by a separate engine. A simple byte-stream port (one received byte per `rx_valid`, one transmit byte per `tx_take`) stands in for the local buffer.

Software supplies the block size as a byte count minus one and an 8-bit block count, then pulses a read or write go. The matching activity flag stays high until the whole group has moved and then clears by itself. Another go after a group ends starts a new group with a fresh count and needs no other setup, so a long transfer can be split into groups of at most 255 blocks. A one-cycle done interrupt marks the end of each group.

Top module: `sd_dat_engine`

## Requirements
- R1: After reset `rd_act`, `wr_act`, `done_irq`, `rd_timeout`, `wr_crc_err`, `rx_valid` and `tx_take` are 0, `dat_oe` is 0000 and `crc_ok` is 1.
- R2: A read group accepts `cfg_blk_cnt` blocks of `cfg_len_m1`+1 bytes each. A block begins with a 0 on DAT0. Bytes arrive most significant bit first: in 1-bit mode one bit per clock on DAT0, in 4-bit mode one nibble per clock on DAT[3:0], high nibble first. Each byte appears once on `rx_data` with a one-cycle `rx_valid`, and `rd_act` clears after the last block.
- R3: A written block drives a start bit 0, the payload most significant bit first, 16 CRC bits per active lane (polynomial x^16+x^12+x^5+1, initial value 0, highest bit first) and an end bit 1, on consecutive clocks. `dat_oe` is 0001 in 1-bit mode and 1111 in 4-bit mode. Each payload byte is taken from `tx_data` in a cycle where `tx_take` is 1.
- R4: After each written block the engine releases the lines and waits for a 0 on DAT0. It then samples three token bits on the next three clocks, ignores one end-bit clock, and waits until DAT0 is 1 before it starts the next block or ends the group. Any token other than 010 sets `wr_crc_err`, which stays set until `crc_err_clr` is pulsed.
- R5: `crc_ok` is set to 1 when a read group starts and cleared when any block's CRC fails on any active lane. A block with a bad CRC does not stop the group.
- R6: If a read waits for a start bit for `TMO_CYC` clocks, `rd_timeout` is set, the group ends and no done pulse is given. The flag clears on the next accepted read go.
- R7: At the normal end of every group `done_irq` pulses for exactly one cycle if `irq_en` is 1, and stays 0 if `irq_en` is 0.
- R8: A go is ignored when `cfg_blk_cnt` is 0 or when a group is already active. If `rd_go` and `wr_go` arrive together, the read starts.
- R9: One go moves up to 255 blocks. After a group ends, a new go with a new count continues at once with that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one DAT bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 selects 4-bit mode, 0 selects 1-bit mode (latched at go) |
| cfg_len_m1 | input | LEN_W | Block size in bytes minus one (latched at go) |
| cfg_blk_cnt | input | CNT_W | Number of blocks for the next go |
| rd_go | input | 1 | Pulse to start a read group |
| wr_go | input | 1 | Pulse to start a write group |
| irq_en | input | 1 | Enables the done pulse |
| crc_err_clr | input | 1 | Pulse to clear `wr_crc_err` |
| rd_act | output | 1 | Read group in progress (self-clearing enable) |
| wr_act | output | 1 | Write group in progress (self-clearing enable) |
| dat_in | input | 4 | DAT[3:0] as seen from the card |
| dat_out | output | 4 | DAT[3:0] driven value |
| dat_oe | output | 4 | Per-lane output enable |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_data` holds a new byte |
| tx_data | input | 8 | Next byte to send |
| tx_take | output | 1 | `tx_data` is consumed at this clock edge |
| crc_ok | output | 1 | All received blocks of the group passed CRC |
| wr_crc_err | output | 1 | Sticky: the card rejected a written block |
| rd_timeout | output | 1 | Read start-bit wait expired |
| done_irq | output | 1 | One-cycle pulse at the end of a group |

## Verification
The bench builds the engine with `LEN_W` = 6 and `TMO_CYC` = 40. Blocks of 1 to 64 bytes can then be streamed and checked lane by lane in both bus widths within a short run, and the start-bit timeout expires after a wait short enough to be counted to the exact cycle. The 8-bit block counter keeps its full width, so a single go of 255 one-byte blocks exercises the group-size limit. Back-to-back groups show that a fresh go continues the transfer with a new count.

// File: rtl/sd_dat_pkg.sv
package sd_dat_pkg;

  localparam int LANES = 4;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [2:0] TOK_ACCEPT = 3'b010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_WAIT,
    S_RD_DATA,
    S_RD_CRC,
    S_RD_END,
    S_WR_START,
    S_WR_DATA,
    S_WR_CRC,
    S_WR_END,
    S_WR_TOKW,
    S_WR_TOK,
    S_WR_TEND,
    S_WR_BUSY
  } xfer_st_e;

  // One serial step of the data CRC16; feeding the register's own MSB shifts it out
  function automatic logic [15:0] crc16_next(input logic [15:0] c, input logic d);
    return {c[14:0], 1'b0} ^ ((c[15] ^ d) ? CRC_POLY : 16'h0000);
  endfunction

endpackage

// File: rtl/sd_crc16_lane.sv
module sd_crc16_lane
  import sd_dat_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic        din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= crc16_next(crc, din);
  end
endmodule

// File: rtl/sd_dn_counter.sv
module sd_dn_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= val;
    else if (dec)  cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/sd_dat_engine.sv
module sd_dat_engine
  import sd_dat_pkg::*;
#(
  parameter int LEN_W   = 9,
  parameter int CNT_W   = 8,
  parameter int TMO_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wide,
  input  logic [LEN_W-1:0] cfg_len_m1,
  input  logic [CNT_W-1:0] cfg_blk_cnt,
  input  logic             rd_go,
  input  logic             wr_go,
  input  logic             irq_en,
  input  logic             crc_err_clr,
  output logic             rd_act,
  output logic             wr_act,
  input  logic [3:0]       dat_in,
  output logic [3:0]       dat_out,
  output logic [3:0]       dat_oe,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_take,
  output logic             crc_ok,
  output logic             wr_crc_err,
  output logic             rd_timeout,
  output logic             done_irq
);
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);

  xfer_st_e st;
  logic             wide_q;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       sh, sh_in;
  logic [2:0]       bit_q;
  logic [3:0]       cyc_q;
  logic [2:0]       tok_q;
  logic [TMO_W-1:0] tmo_q;
  logic [LEN_W-1:0] byte_left;
  logic [CNT_W-1:0] blk_left;
  logic [LANES-1:0] lane_mask, crc_din, crc_fail, tx_bits, crc_msb;
  logic [15:0]      crc_q [LANES];
  logic bit_last, byte_last, blk_last, byte_end, blk_end;
  logic crc_en, crc_clr, go_rd, go_wr;

  assign rd_act    = (st == S_RD_WAIT) || (st == S_RD_DATA) || (st == S_RD_CRC) || (st == S_RD_END);
  assign wr_act    = (st != S_IDLE) && !rd_act;
  assign lane_mask = wide_q ? 4'hF : 4'h1;
  assign bit_last  = wide_q ? (bit_q == 3'd1) : (bit_q == 3'd7);
  assign byte_last = (byte_left == '0);
  assign blk_last  = (blk_left == CNT_W'(1));
  assign byte_end  = ((st == S_RD_DATA) || (st == S_WR_DATA)) && bit_last;
  assign blk_end   = (st == S_RD_END) || ((st == S_WR_BUSY) && dat_in[0]);
  assign go_rd     = (st == S_IDLE) && rd_go && (cfg_blk_cnt != '0);
  assign go_wr     = (st == S_IDLE) && wr_go && !rd_go && (cfg_blk_cnt != '0);
  assign sh_in     = wide_q ? {sh[3:0], dat_in} : {sh[6:0], dat_in[0]};
  assign tx_bits   = wide_q ? sh[7:4] : {3'b111, sh[7]};
  assign tx_take   = (st == S_WR_START) || ((st == S_WR_DATA) && bit_last && !byte_last);
  assign crc_en    = (st == S_RD_DATA) || (st == S_RD_CRC) || (st == S_WR_DATA) || (st == S_WR_CRC);
  assign crc_clr   = (st == S_RD_WAIT) || (st == S_WR_START);

  sd_dn_counter #(.W(LEN_W)) u_bytes (
    .clk(clk), .rst(rst), .load(crc_clr), .dec(byte_end), .val(len_q), .cnt(byte_left));

  sd_dn_counter #(.W(CNT_W)) u_blocks (
    .clk(clk), .rst(rst), .load(go_rd || go_wr), .dec(blk_end), .val(cfg_blk_cnt), .cnt(blk_left));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sd_crc16_lane u_crc (
      .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en && lane_mask[l]),
      .din(crc_din[l]), .crc(crc_q[l]));
    assign crc_msb[l]  = crc_q[l][15];
    assign crc_fail[l] = lane_mask[l] && (crc_q[l] != 16'h0000);
  end

  // Reads feed the received CRC into the LFSR (a good block leaves zero);
  // writes feed the payload, then the register's own MSB to shift the CRC out.
  always_comb begin
    case (st)
      S_WR_DATA: crc_din = tx_bits;
      S_WR_CRC:  crc_din = crc_msb;
      default:   crc_din = dat_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      wide_q <= 1'b0;
      len_q <= '0;
      sh <= '0;
      bit_q <= '0;
      cyc_q <= '0;
      tok_q <= '0;
      tmo_q <= '0;
      dat_out <= 4'hF;
      dat_oe <= 4'h0;
      rx_data <= '0;
      rx_valid <= 1'b0;
      crc_ok <= 1'b1;
      wr_crc_err <= 1'b0;
      rd_timeout <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      done_irq <= 1'b0;
      if (crc_err_clr) wr_crc_err <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go_rd || go_wr) begin
            wide_q <= cfg_wide;
            len_q <= cfg_len_m1;
            tmo_q <= '0;
          end
          if (go_rd) begin
            st <= S_RD_WAIT;
            crc_ok <= 1'b1;
            rd_timeout <= 1'b0;
          end else if (go_wr) begin
            st <= S_WR_START;
          end
        end
        S_RD_WAIT: begin
          if (!dat_in[0]) begin
            st <= S_RD_DATA;
            bit_q <= '0;
          end else if (tmo_q == TMO_LAST) begin
            rd_timeout <= 1'b1;
            st <= S_IDLE;
          end else begin
            tmo_q <= tmo_q + TMO_W'(1);
          end
        end
        S_RD_DATA: begin
          sh <= sh_in;
          bit_q <= bit_q + 3'd1;
          if (bit_last) begin
            bit_q <= '0;
            rx_data <= sh_in;
            rx_valid <= 1'b1;
            if (byte_last) begin
              st <= S_RD_CRC;
              cyc_q <= '0;
            end
          end
        end
        S_RD_CRC: begin
          cyc_q <= cyc_q + 4'd1;
          if (cyc_q == 4'd15) st <= S_RD_END;
        end
        S_RD_END: begin
          if (crc_fail != '0) crc_ok <= 1'b0;
          tmo_q <= '0;
          if (blk_last) begin
            st <= S_IDLE;
            done_irq <= irq_en;
          end else begin
            st <= S_RD_WAIT;
          end
        end
        S_WR_START: begin
          dat_oe <= lane_mask;
          dat_out <= 4'h0;
          sh <= tx_data;
          bit_q <= '0;
          st <= S_WR_DATA;
        end
        S_WR_DATA: begin
          dat_out <= tx_bits;
          sh <= wide_q ? {sh[3:0], 4'h0} : {sh[6:0], 1'b0};
          bit_q <= bit_q + 3'd1;
          if (bit_last) begin
            bit_q <= '0;
            if (byte_last) begin
              st <= S_WR_CRC;
              cyc_q <= '0;
            end else begin
              sh <= tx_data;
            end
          end
        end
        S_WR_CRC: begin
          dat_out <= crc_msb;
          cyc_q <= cyc_q + 4'd1;
          if (cyc_q == 4'd15) st <= S_WR_END;
        end
        S_WR_END: begin
          dat_out <= 4'hF;
          st <= S_WR_TOKW;
        end
        S_WR_TOKW: begin
          dat_oe <= 4'h0;
          if (!dat_in[0]) begin
            st <= S_WR_TOK;
            cyc_q <= '0;
          end
        end
        S_WR_TOK: begin
          tok_q <= {tok_q[1:0], dat_in[0]};
          cyc_q <= cyc_q + 4'd1;
          if (cyc_q == 4'd2) st <= S_WR_TEND;
        end
        S_WR_TEND: begin
          if (tok_q != TOK_ACCEPT) wr_crc_err <= 1'b1;
          st <= S_WR_BUSY;
        end
        S_WR_BUSY: begin
          if (dat_in[0]) begin
            if (blk_last) begin
              st <= S_IDLE;
              done_irq <= irq_en;
            end else begin
              st <= S_WR_START;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_dat_engine_chk.sv
module sd_dat_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_act,
  input logic       wr_act,
  input logic [3:0] dat_oe,
  input logic       rx_valid,
  input logic       tx_take,
  input logic       irq_en,
  input logic       rd_timeout,
  input logic       done_irq
);
  assert_oe_write_R3: assert property (@(posedge clk) disable iff (rst)
    (dat_oe != 4'h0) |-> wr_act);

  assert_take_write_R3: assert property (@(posedge clk) disable iff (rst)
    tx_take |-> wr_act);

  assert_rx_read_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rd_act);

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  assert_rd_end_irq_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_act) && !rd_timeout) |-> (done_irq == $past(irq_en)));

  assert_tmo_ends_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_timeout) |-> (!rd_act && !done_irq));
endmodule

bind sd_dat_engine sd_dat_engine_chk u_chk (
  .clk(clk), .rst(rst), .rd_act(rd_act), .wr_act(wr_act), .dat_oe(dat_oe),
  .rx_valid(rx_valid), .tx_take(tx_take), .irq_en(irq_en),
  .rd_timeout(rd_timeout), .done_irq(done_irq));

// File: tb/test_sd_dat_engine.sv
`timescale 1ns/1ps
module test_sd_dat_engine;
  localparam int LEN_W = 6;
  localparam int TMO   = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wide = 1'b0, rd_go = 1'b0, wr_go = 1'b0, irq_en = 1'b1, crc_err_clr = 1'b0;
  logic [LEN_W-1:0] cfg_len_m1 = '0;
  logic [7:0] cfg_blk_cnt = '0;
  logic rd_act, wr_act, rx_valid, tx_take, crc_ok, wr_crc_err, rd_timeout, done_irq;
  logic [3:0] dat_in = 4'hF, dat_out, dat_oe;
  logic [7:0] rx_data, tx_data = '0;

  int n_chk = 0, n_fail = 0;
  int rx_n = 0, irq_n = 0, wr_errs = 0;
  int tx_idx = 0, tx_seed = 0;
  bit tx_pend = 1'b0;
  logic [7:0] rx_buf [512];

  always #2.5 clk = ~clk;

  sd_dat_engine #(.LEN_W(LEN_W), .CNT_W(8), .TMO_CYC(TMO)) i_sd_dat_engine (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_len_m1(cfg_len_m1),
    .cfg_blk_cnt(cfg_blk_cnt), .rd_go(rd_go), .wr_go(wr_go), .irq_en(irq_en),
    .crc_err_clr(crc_err_clr), .rd_act(rd_act), .wr_act(wr_act), .dat_in(dat_in),
    .dat_out(dat_out), .dat_oe(dat_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_take(tx_take), .crc_ok(crc_ok), .wr_crc_err(wr_crc_err),
    .rd_timeout(rd_timeout), .done_irq(done_irq));

  // Vector: [23] write, [22] 4-bit, [21:16] len-1, [15:8] blocks, [7:0] seed
  localparam logic [23:0] VEC [6] = '{
    {1'b0, 1'b0, 6'd7,  8'd2, 8'd11},
    {1'b0, 1'b1, 6'd15, 8'd3, 8'd22},
    {1'b0, 1'b1, 6'd0,  8'd1, 8'd33},
    {1'b1, 1'b0, 6'd3,  8'd2, 8'd44},
    {1'b1, 1'b1, 6'd7,  8'd3, 8'd55},
    {1'b1, 1'b1, 6'd63, 8'd1, 8'd66}
  };

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 7 + k * 13 + (k >> 3)) & 255);
  endfunction

  function automatic logic [15:0] crc_add(input logic [15:0] c, input logic d);
    logic [15:0] r;
    r = c << 1;
    if (c[15] ^ d) r = r ^ 16'h1021;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_buf[rx_n % 512] = rx_data;
      rx_n++;
    end
    if (done_irq) irq_n++;
    if (tx_pend) tx_idx++;
    tx_pend = tx_take;
    tx_data = pat(tx_seed, tx_idx);
  end

  // Card side of a read: gap, start bit, payload, CRC per lane, end bit
  task automatic card_send(input bit wide, input int len, input int cnt, input int seed,
                           input int bad_blk);
    logic [15:0] c [4];
    logic [7:0] b;
    logic [3:0] nib;
    for (int blk = 0; blk < cnt; blk++) begin
      repeat (3) @(negedge clk) dat_in = 4'hF;
      @(negedge clk) dat_in = wide ? 4'h0 : 4'hE;
      for (int l = 0; l < 4; l++) c[l] = 16'h0;
      for (int i = 0; i <= len; i++) begin
        b = pat(seed, blk * (len + 1) + i);
        if (wide) begin
          for (int h = 1; h >= 0; h--) begin
            nib = h ? b[7:4] : b[3:0];
            @(negedge clk) dat_in = nib;
            for (int l = 0; l < 4; l++) c[l] = crc_add(c[l], nib[l]);
          end
        end else begin
          for (int k = 7; k >= 0; k--) begin
            @(negedge clk) dat_in = {3'b111, b[k]};
            c[0] = crc_add(c[0], b[k]);
          end
        end
      end
      if (blk == bad_blk) c[0][0] = ~c[0][0];
      for (int k = 15; k >= 0; k--)
        @(negedge clk) dat_in = wide ? {c[3][k], c[2][k], c[1][k], c[0][k]} : {3'b111, c[0][k]};
      @(negedge clk) dat_in = 4'hF;
    end
  endtask

  // Card side of a write: capture, compare, answer with token and busy
  task automatic card_recv(input bit wide, input int len, input int cnt, input int seed,
                           input int bad_blk);
    logic [15:0] c [4];
    logic [7:0] b;
    logic [3:0] m;
    logic [2:0] tok;
    m = wide ? 4'hF : 4'h1;
    for (int blk = 0; blk < cnt; blk++) begin
      @(negedge clk);
      while (!(dat_oe[0] && !dat_out[0])) @(negedge clk);
      if (dat_oe != m) wr_errs++;
      for (int l = 0; l < 4; l++) c[l] = 16'h0;
      for (int i = 0; i <= len; i++) begin
        b = '0;
        if (wide) begin
          for (int h = 0; h < 2; h++) begin
            @(negedge clk);
            b = {b[3:0], dat_out};
            for (int l = 0; l < 4; l++) c[l] = crc_add(c[l], dat_out[l]);
          end
        end else begin
          for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            b = {b[6:0], dat_out[0]};
            c[0] = crc_add(c[0], dat_out[0]);
          end
        end
        if (b != pat(seed, blk * (len + 1) + i)) wr_errs++;
      end
      for (int k = 15; k >= 0; k--) begin
        @(negedge clk);
        for (int l = 0; l < 4; l++)
          if (m[l] && (dat_out[l] != c[l][k])) wr_errs++;
      end
      @(negedge clk);
      if ((dat_out & m) != m) wr_errs++;
      @(negedge clk);
      @(negedge clk) dat_in = 4'hE;
      tok = (blk == bad_blk) ? 3'b101 : 3'b010;
      for (int k = 2; k >= 0; k--) @(negedge clk) dat_in = {3'b111, tok[k]};
      @(negedge clk) dat_in = 4'hF;
      repeat (4) @(negedge clk) dat_in = 4'hE;
      @(negedge clk) dat_in = 4'hF;
    end
  endtask

  task automatic run_rd(input bit wide, input int len, input int cnt, input int seed,
                        input int bad_blk, input bit irq, input bit poke);
    int errs;
    rx_n = 0; irq_n = 0; irq_en = irq;
    cfg_wide = wide; cfg_len_m1 = LEN_W'(len); cfg_blk_cnt = 8'(cnt);
    @(negedge clk) rd_go = 1'b1;
    @(negedge clk) rd_go = 1'b0;
    check(rd_act == 1'b1, "R2 read active after go", int'(rd_act), 1);
    if (poke) begin
      wr_go = 1'b1;
      @(negedge clk) wr_go = 1'b0;
      check(wr_act == 1'b0 && rd_act == 1'b1, "R8 go while busy ignored", int'(wr_act), 0);
    end
    card_send(wide, len, cnt, seed, bad_blk);
    while (rd_act) @(negedge clk);
    @(negedge clk);
    check(rx_n == (len + 1) * cnt, "R2 R9 received byte count", rx_n, (len + 1) * cnt);
    errs = 0;
    for (int k = 0; k < rx_n && k < 512; k++) if (rx_buf[k] != pat(seed, k)) errs++;
    check(errs == 0, "R2 received byte values", errs, 0);
    check(crc_ok == (bad_blk < 0), "R5 crc_ok after read", int'(crc_ok), int'(bad_blk < 0));
    check(irq_n == int'(irq), "R7 done pulses after read", irq_n, int'(irq));
  endtask

  task automatic run_wr(input bit wide, input int len, input int cnt, input int seed,
                        input int bad_blk);
    wr_errs = 0; irq_n = 0; irq_en = 1'b1;
    tx_seed = seed; tx_idx = 0; tx_pend = 1'b0;
    cfg_wide = wide; cfg_len_m1 = LEN_W'(len); cfg_blk_cnt = 8'(cnt);
    @(negedge clk) wr_go = 1'b1;
    @(negedge clk) wr_go = 1'b0;
    check(wr_act == 1'b1, "R3 write active after go", int'(wr_act), 1);
    card_recv(wide, len, cnt, seed, bad_blk);
    while (wr_act) @(negedge clk);
    @(negedge clk);
    check(wr_errs == 0, "R3 write framing, data and CRC", wr_errs, 0);
    check(tx_idx == (len + 1) * cnt, "R3 bytes taken", tx_idx, (len + 1) * cnt);
    check(wr_crc_err == (bad_blk >= 0), "R4 token flag", int'(wr_crc_err), int'(bad_blk >= 0));
    check(irq_n == 1, "R7 done pulse after write", irq_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!rd_act && !wr_act && dat_oe == 4'h0, "R1 idle after reset", int'(dat_oe), 0);
    check(crc_ok && !wr_crc_err && !rd_timeout && !done_irq && !rx_valid && !tx_take,
          "R1 flags after reset", int'(crc_ok), 1);
    rst = 1'b0;

    foreach (VEC[i]) begin
      if (VEC[i][23])
        run_wr(VEC[i][22], int'(VEC[i][21:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]), -1);
      else
        run_rd(VEC[i][22], int'(VEC[i][21:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]), -1,
               1'b1, 1'b0);
    end

    // R5: second of two blocks has a bad CRC, group still completes
    run_rd(1'b0, 3, 2, 77, 1, 1'b1, 1'b0);
    // R5: bad CRC on a 4-bit read, lane 0 only
    run_rd(1'b1, 5, 1, 78, 0, 1'b1, 1'b0);
    // R7: no done pulse with irq_en low; R8: write go during read ignored
    run_rd(1'b1, 3, 1, 79, -1, 1'b0, 1'b1);
    // R9: back-to-back groups with fresh counts, then a full 255-block group
    run_rd(1'b0, 1, 1, 80, -1, 1'b1, 1'b0);
    run_rd(1'b0, 1, 2, 81, -1, 1'b1, 1'b0);
    run_rd(1'b1, 0, 255, 82, -1, 1'b1, 1'b0);

    // R4: rejected second block sets the sticky flag, clear input drops it
    run_wr(1'b1, 3, 2, 90, 1);
    @(negedge clk) crc_err_clr = 1'b1;
    @(negedge clk) crc_err_clr = 1'b0;
    check(wr_crc_err == 1'b0, "R4 clear of token flag", int'(wr_crc_err), 0);
    run_wr(1'b0, 1, 1, 91, -1);

    // R8: zero count ignored for both directions
    cfg_blk_cnt = 8'd0;
    @(negedge clk) begin rd_go = 1'b1; wr_go = 1'b1; end
    @(negedge clk) begin rd_go = 1'b0; wr_go = 1'b0; end
    check(!rd_act && !wr_act, "R8 zero count ignored", int'(rd_act | wr_act), 0);

    // R8: simultaneous go starts the read; R6: no card, timeout after TMO clocks
    irq_n = 0; irq_en = 1'b1; cfg_blk_cnt = 8'd1; dat_in = 4'hF;
    @(negedge clk) begin rd_go = 1'b1; wr_go = 1'b1; end
    @(negedge clk) begin rd_go = 1'b0; wr_go = 1'b0; end
    check(rd_act && !wr_act, "R8 read wins on simultaneous go", int'(wr_act), 0);
    n = 0;
    while (rd_act) begin
      @(negedge clk);
      n++;
    end
    check(n == TMO, "R6 timeout cycle", n, TMO);
    check(rd_timeout == 1'b1, "R6 timeout flag", int'(rd_timeout), 1);
    @(negedge clk);
    check(irq_n == 0, "R6 no done pulse on timeout", irq_n, 0);
    // R6: flag clears on the next read go
    run_rd(1'b0, 0, 1, 92, -1, 1'b1, 1'b0);
    check(rd_timeout == 1'b0, "R6 timeout cleared by next go", int'(rd_timeout), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule